// File: doc/BRIEF.md
# Programmable Interrupt Priority Resolver

This block chooses one interrupt out of six request lines, numbered 0 to 5, and reports its index. The six lines form three pairs, called group A (lines 3 and 5), group B (lines 0 and 2) and group C (lines 1 and 4). A write-only 8-bit priority byte sets the ranking on two levels. A 3-bit code sets the order of the three groups. One bit per group sets which of its two lines wins inside that group.

Each request pulse latches into a pending bit. A pending line can compete only when its mask bit and the global enable are both set. The winner and its valid flag are registered once per clock. An acknowledge pulse clears the pending bit of the index that is currently reported. Vector generation, stacking and processor sequencing are left to the surrounding logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: A 1 on `req_in[i]` at a clock edge sets pending bit i. The bit stays set until an acknowledge clears it or a reset occurs.
- R2: Line i is eligible only if pending bit i, `mask_in[i]` and `gen_in` are all 1. A line that is not eligible never changes the result.
- R3: Inside each group, a select bit in the priority byte sets the winner. Group C uses D1: 0 means line 1 wins, 1 means line 4 wins. Group B uses D2: 0 means line 2 wins, 1 means line 0 wins. Group A uses D5: 0 means line 5 wins, 1 means line 3 wins. A lone eligible line in a group always wins that group.
- R4: The group-order code is {D4,D3,D0}. The orders are: 010 is A>B>C, 011 is A>C>B, 110 is B>A>C, 100 is B>C>A, 001 is C>A>B and 101 is C>B>A. The reported line comes from the highest-ranked group that has an eligible line.
- R5: While the stored code is 000 or 111, `irq_vld` is 0.
- R6: The outputs are registered. After a clock edge they reflect the requests, mask, enable and priority write present at that edge, together with the pending state.
- R7: If `ack_in` is 1 at an edge while `irq_vld` is 1, pending bit `irq_id` is cleared at that edge. If `req_in` sets the same line at that edge, the bit stays set.
- R8: Reset clears every pending bit and the priority byte, and drives `irq_vld` to 0 and `irq_id` to 0.
- R9: Bits D7 and D6 of the priority byte have no effect on the result.
- R10: When `irq_vld` is 0, `irq_id` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| prio_wr | input | 1 | Write strobe for the priority byte |
| prio_wdata | input | 8 | Priority byte written when `prio_wr` is 1 |
| req_in | input | 6 | Request pulses that set pending bits |
| mask_in | input | 6 | Per-line enable mask |
| gen_in | input | 1 | Global enable |
| ack_in | input | 1 | Acknowledge of the reported line |
| irq_vld | output | 1 | A winner is being reported |
| irq_id | output | 3 | Index of the winning line |

## Verification
The assertions assume that `ack_in` is only meaningful while `irq_vld` is high. They also assume that `mask_in`, `gen_in` and `req_in` are stable around the clock edge. The bench changes every input on the falling edge and samples the outputs one falling edge later, after exactly one registered update. A reset comes before every table vector, so each one starts with no pending bits. The directed acknowledge tests raise `ack_in` only while a winner is being shown.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_IRQ = 6;
  localparam int ID_W    = $clog2(NUM_IRQ);
  localparam int NUM_GRP = NUM_IRQ / 2;
  localparam int GRP_W   = 2;

  typedef enum logic [GRP_W-1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_C = 2'd2} grp_e;

  typedef struct packed {
    logic [2:0] code;
    logic       sel_a;
    logic       sel_b;
    logic       sel_c;
  } prio_cfg_t;

  function automatic prio_cfg_t unpack_prio(input logic [7:0] b);
    prio_cfg_t c;
    c.code  = {b[4], b[3], b[0]};
    c.sel_a = b[5];
    c.sel_b = b[2];
    c.sel_c = b[1];
    return c;
  endfunction

  function automatic logic code_is_rsvd(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b111);
  endfunction

  // rank[0] is the top group, rank[2] the lowest
  function automatic logic [3*GRP_W-1:0] rank_of(input logic [2:0] code);
    case (code)
      3'b001:  return {GRP_B, GRP_A, GRP_C};
      3'b010:  return {GRP_C, GRP_B, GRP_A};
      3'b011:  return {GRP_B, GRP_C, GRP_A};
      3'b100:  return {GRP_A, GRP_C, GRP_B};
      3'b101:  return {GRP_A, GRP_B, GRP_C};
      3'b110:  return {GRP_C, GRP_A, GRP_B};
      default: return {GRP_C, GRP_B, GRP_A};
    endcase
  endfunction
endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] prio_q,
  output logic [7:0] prio_d
);
  always_comb begin
    prio_d = prio_q;
    if (wr) prio_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else if (wr) prio_q <= prio_d;
  end
endmodule

// File: rtl/irq_pair_pick.sv
module irq_pair_pick
  import irq_prio_pkg::*;
#(
  parameter int IDX_LO_SEL = 0,  // wins when sel = 0
  parameter int IDX_HI_SEL = 1   // wins when sel = 1
) (
  input  logic [NUM_IRQ-1:0] elig,
  input  logic               sel,
  output logic               vld,
  output logic [ID_W-1:0]    id
);
  localparam logic [ID_W-1:0] ID_LO = ID_W'(IDX_LO_SEL);
  localparam logic [ID_W-1:0] ID_HI = ID_W'(IDX_HI_SEL);

  logic e_lo, e_hi;
  assign e_lo = elig[IDX_LO_SEL];
  assign e_hi = elig[IDX_HI_SEL];

  always_comb begin
    vld = e_lo | e_hi;
    if (e_lo && e_hi) id = sel ? ID_HI : ID_LO;
    else if (e_hi)    id = ID_HI;
    else              id = ID_LO;
  end
endmodule

// File: rtl/irq_group_order.sv
module irq_group_order
  import irq_prio_pkg::*;
(
  input  logic [2:0]               code,
  input  logic [NUM_GRP-1:0]       grp_vld,
  input  logic [NUM_GRP*ID_W-1:0]  grp_id,
  output logic                     vld,
  output logic [ID_W-1:0]          id
);
  logic [3*GRP_W-1:0] rank;
  assign rank = rank_of(code);

  always_comb begin
    vld = 1'b0;
    id  = '0;
    if (!code_is_rsvd(code)) begin
      for (int r = NUM_GRP - 1; r >= 0; r--) begin
        if (grp_vld[rank[r*GRP_W +: GRP_W]]) begin
          vld = 1'b1;
          id  = grp_id[rank[r*GRP_W +: GRP_W]*ID_W +: ID_W];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prio_wr,
  input  logic [7:0]         prio_wdata,
  input  logic [NUM_IRQ-1:0] req_in,
  input  logic [NUM_IRQ-1:0] mask_in,
  input  logic               gen_in,
  input  logic               ack_in,
  output logic               irq_vld,
  output logic [ID_W-1:0]    irq_id
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // priority byte
  logic [7:0] prio_q, prio_d;
  prio_cfg_t  cfg_d, cfg_q;

  irq_prio_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr     (prio_wr),
    .wdata  (prio_wdata),
    .prio_q (prio_q),
    .prio_d (prio_d)
  );
  assign cfg_d = unpack_prio(prio_d);
  assign cfg_q = unpack_prio(prio_q);

  // pending state
  logic [NUM_IRQ-1:0] pend_q, pend_d, clr_vec;
  logic               vld_q, vld_d;
  logic [ID_W-1:0]    id_q, id_d;

  always_comb begin
    clr_vec = '0;
    if (ack_in && vld_q) clr_vec = NUM_IRQ'(1) << id_q;
    pend_d = (pend_q & ~clr_vec) | req_in;
  end

  logic [NUM_IRQ-1:0] elig;
  assign elig = pend_d & mask_in & {NUM_IRQ{gen_in}};

  // group pickers: A = {5 | 3}, B = {2 | 0}, C = {1 | 4}
  localparam int LO_IDX [NUM_GRP] = '{5, 2, 1};
  localparam int HI_IDX [NUM_GRP] = '{3, 0, 4};

  logic [NUM_GRP-1:0]      grp_sel;
  logic [NUM_GRP-1:0]      grp_vld;
  logic [NUM_GRP*ID_W-1:0] grp_id;

  assign grp_sel = {cfg_d.sel_c, cfg_d.sel_b, cfg_d.sel_a};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
    irq_pair_pick #(
      .IDX_LO_SEL (LO_IDX[g]),
      .IDX_HI_SEL (HI_IDX[g])
    ) u_pick (
      .elig (elig),
      .sel  (grp_sel[g]),
      .vld  (grp_vld[g]),
      .id   (grp_id[g*ID_W +: ID_W])
    );
  end

  irq_group_order u_order (
    .code    (cfg_d.code),
    .grp_vld (grp_vld),
    .grp_id  (grp_id),
    .vld     (vld_d),
    .id      (id_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      id_q   <= id_d;
    end
  end

  assign irq_vld = vld_q;
  assign irq_id  = id_q;

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_q |-> !code_is_rsvd(cfg_q.code)); // R5
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_q |-> pend_q[id_q]); // R2
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_q |-> $past(gen_in)); // R2
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|req_in) |=> ((pend_q & $past(req_in)) == $past(req_in))); // R1
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_in && vld_q && !req_in[id_q]) |=> !pend_q[$past(id_q)]); // R7
  AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !vld_q |-> (id_q == '0)); // R10
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       prio_wr;
  logic [7:0] prio_wdata;
  logic [5:0] req_in, mask_in;
  logic       gen_in, ack_in;
  logic       irq_vld;
  logic [2:0] irq_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .prio_wr(prio_wr), .prio_wdata(prio_wdata),
    .req_in(req_in), .mask_in(mask_in), .gen_in(gen_in), .ack_in(ack_in),
    .irq_vld(irq_vld), .irq_id(irq_id)
  );

  // fields: code[15:13] selA[12] selB[11] selC[10] pend[9:4] vld[3] id[2:0]
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {3'b010, 1'b0, 1'b0, 1'b0, 6'h3F,      1'b1, 3'd5},
    {3'b010, 1'b1, 1'b0, 1'b0, 6'h3F,      1'b1, 3'd3},
    {3'b001, 1'b0, 1'b0, 1'b0, 6'h3F,      1'b1, 3'd1},
    {3'b001, 1'b0, 1'b0, 1'b1, 6'h3F,      1'b1, 3'd4},
    {3'b100, 1'b0, 1'b0, 1'b0, 6'h3F,      1'b1, 3'd2},
    {3'b100, 1'b0, 1'b1, 1'b0, 6'h3F,      1'b1, 3'd0},
    {3'b101, 1'b0, 1'b0, 1'b0, 6'b001001,  1'b1, 3'd0},
    {3'b011, 1'b0, 1'b0, 1'b0, 6'b010001,  1'b1, 3'd4},
    {3'b110, 1'b0, 1'b0, 1'b0, 6'b101010,  1'b1, 3'd5},
    {3'b000, 1'b0, 1'b0, 1'b0, 6'h3F,      1'b0, 3'd0},
    {3'b111, 1'b0, 1'b0, 1'b0, 6'h3F,      1'b0, 3'd0},
    {3'b010, 1'b0, 1'b0, 1'b0, 6'b000010,  1'b1, 3'd1},
    {3'b010, 1'b0, 1'b0, 1'b0, 6'b001000,  1'b1, 3'd3},
    {3'b101, 1'b0, 1'b1, 1'b0, 6'b100100,  1'b1, 3'd2}
  };

  function automatic logic [7:0] mk(input logic [2:0] c, input logic sa, input logic sb,
                                    input logic sc, input logic [1:0] top);
    return {top, sa, c[2], c[1], sb, sc, c[0]};
  endfunction

  task automatic check(input string req, input logic ev, input logic [2:0] eid);
    checks++;
    if (irq_vld !== ev || irq_id !== eid) begin
      errors++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
               req, irq_vld, irq_id, ev, eid);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; prio_wr = 1'b0; prio_wdata = '0; req_in = '0;
    mask_in = '0; gen_in = 1'b0; ack_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive one cycle at a falling edge, then sample after the rising edge
  task automatic step(input logic wr, input logic [7:0] wd, input logic [5:0] rq,
                      input logic [5:0] mk_in, input logic ge, input logic ak);
    prio_wr = wr; prio_wdata = wd; req_in = rq; mask_in = mk_in; gen_in = ge; ack_in = ak;
    @(negedge clk);
    prio_wr = 1'b0; req_in = '0; ack_in = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    check("R8 reset idle", 1'b0, 3'd0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      do_reset();
      step(1'b1, mk(v[15:13], v[12], v[11], v[10], 2'b00), v[9:4], 6'h3F, 1'b1, 1'b0);
      check($sformatf("R4/R3/R5 vector %0d", i), v[3], v[2:0]);
    end

    // R1: pending held with no further requests
    do_reset();
    step(1'b1, mk(3'b010, 1'b0, 1'b0, 1'b0, 2'b00), 6'b000100, 6'h3F, 1'b1, 1'b0);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b0);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b0);
    check("R1 pending held", 1'b1, 3'd2);

    // R2: mask removes line 5, then global enable off, then back on
    do_reset();
    step(1'b1, mk(3'b010, 1'b0, 1'b0, 1'b0, 2'b00), 6'h3F, 6'b011111, 1'b1, 1'b0);
    check("R2 masked line", 1'b1, 3'd3);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b0, 1'b0);
    check("R2 global disable", 1'b0, 3'd0);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b0);
    check("R2 reenabled", 1'b1, 3'd5);

    // R9: top bits set do not alter the ranking
    step(1'b1, mk(3'b001, 1'b0, 1'b0, 1'b1, 2'b11), 6'h00, 6'h3F, 1'b1, 1'b0);
    check("R9 upper bits ignored", 1'b1, 3'd4);

    // R6: rewrite priority with pending unchanged
    step(1'b1, mk(3'b100, 1'b0, 1'b1, 1'b0, 2'b00), 6'h00, 6'h3F, 1'b1, 1'b0);
    check("R6 new order at write edge", 1'b1, 3'd0);

    // R7: acknowledge sequence
    do_reset();
    step(1'b1, mk(3'b010, 1'b0, 1'b0, 1'b0, 2'b00), 6'b101000, 6'h3F, 1'b1, 1'b0);
    check("R7 before ack", 1'b1, 3'd5);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b1);
    check("R7 first ack", 1'b1, 3'd3);
    step(1'b0, 8'h00, 6'b001000, 6'h3F, 1'b1, 1'b1);
    check("R7 ack with same-line request", 1'b1, 3'd3);
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b1);
    check("R7 last ack, R10 id idle", 1'b0, 3'd0);

    // R8: reset wipes pending state and priority
    step(1'b1, mk(3'b010, 1'b0, 1'b0, 1'b0, 2'b00), 6'h3F, 6'h3F, 1'b1, 1'b0);
    do_reset();
    step(1'b0, 8'h00, 6'h00, 6'h3F, 1'b1, 1'b0);
    check("R8 nothing after reset", 1'b0, 3'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule